// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 16-bit processor core and gathers a set of external interrupt request lines. A rising edge on any line records that line as pending. Among the pending lines, a fixed priority picks one winner: the line with the lowest index wins. The controller does not break into an instruction partway through. It raises its interrupt output only in a cycle where the core reports that an instruction has just completed. In that same cycle it presents the winning source number and the start address of that source's service routine.

After the interrupt output has fired, the controller stays quiet until the core acknowledges the interrupt and names the source it served. The acknowledge clears that source's pending bit. Any request still pending is then offered at the very next instruction boundary. Requests that arrive together are therefore served one after another, in priority order, and none is lost. Once nothing is pending, the core simply keeps running its program. A global enable input gates the interrupt output without discarding pending requests. The service routine addresses come from a parameter table with one entry per source. Each address is forced to word alignment.

Top module: `irqVecCtrl`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears every pending bit and returns the controller to its idle state. In the first cycle after reset, `intReq` is low and `intId` and `intVector` are zero.
- R2: A low-to-high transition on `irqReq[i]` sets the pending bit of source i. A line held high produces no further pending event after its bit has been cleared.
- R3: `intReq` is high only in a cycle where `instrDone` is high, `globalEn` is high, at least one source is pending, and no earlier interrupt is still waiting for acknowledge.
- R4: When several sources are pending, the one with the lowest index is presented, and `intId` carries that index.
- R5: While `intReq` is high, `intVector` equals the parameter table entry for `intId` with bit 0 cleared. With the default table, source i gets address 0xF000 + 0x10·(i+1).
- R6: A cycle with `ackValid` high clears the pending bit selected by `ackId`, even if the controller is idle. If a new rising edge on that same source arrives in the same cycle, the bit stays set.
- R7: While `globalEn` is low, `intReq` stays low. Requests stay pending and are presented at the first boundary after `globalEn` returns high.
- R8: After `intReq` fires, it stays low until an `ackValid` cycle. The next pending request is then presented at the first `instrDone` cycle after that acknowledge.
- R9: Whenever `intReq` is low, `intId` and `intVector` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqReq | input | NUM_SRC | External request lines, rising-edge sensitive |
| globalEn | input | 1 | Global interrupt enable |
| instrDone | input | 1 | Strobe from the core marking the end of an instruction |
| ackValid | input | 1 | Acknowledge strobe from the core |
| ackId | input | IDX_W | Source being acknowledged |
| intReq | output | 1 | Interrupt request to the core |
| intId | output | IDX_W | Index of the source being presented |
| intVector | output | ADDR_W | Start address of that source's service routine |

## Verification
The properties take some things about the core for granted. The core pulses `ackValid` only after it has taken an interrupt, and it names in `ackId` the source it was given. It may also issue a stray acknowledge while idle, because R6 allows that. The properties never require `instrDone` to arrive on any particular schedule. The stimulus keeps to these assumptions. It acknowledges each presented source by its own index. It drives `instrDone` only as single boundary cycles or held low. It changes request lines only away from the clock edge, which makes every edge on `irqReq` a clean single-cycle transition.

// File: rtl/irqCtrlPkg.sv
package irqCtrlPkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic fire;   // present the winning source to the core this cycle
    logic clear;  // drop the pending bit named by the acknowledge index
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_WAIT_ACK = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/irqCtrlDatapath.sv
module irqCtrlDatapath
  import irqCtrlPkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SRC-1:0][ADDR_W-1:0] VEC_TABLE = '0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [IDX_W-1:0]   ackId,
  input  ctrlStrobes_t       strobes,
  output logic               anyPending,
  output logic [IDX_W-1:0]   intId,
  output logic [ADDR_W-1:0]  intVector
);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] reqRise;
  logic [IDX_W-1:0]   winId;
  logic               winFound;

  assign reqRise = irqReq & ~reqPrev;

  always_ff @(posedge clk) begin
    if (rst) reqPrev <= '0;
    else     reqPrev <= irqReq;
  end

  // One pending flop per source; a fresh edge outranks a same-cycle clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    logic ackHit;
    assign ackHit = strobes.clear && (ackId == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)             pending[g] <= 1'b0;
      else if (reqRise[g]) pending[g] <= 1'b1;
      else if (ackHit)     pending[g] <= 1'b0;
    end
  end

  // Fixed priority: lowest index wins
  always_comb begin
    winId    = '0;
    winFound = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && !winFound) begin
        winId    = IDX_W'(i);
        winFound = 1'b1;
      end
    end
  end

  assign anyPending = winFound;

  always_comb begin
    intId     = '0;
    intVector = '0;
    if (strobes.fire) begin
      intId     = winId;
      intVector = {VEC_TABLE[winId][ADDR_W-1:1], 1'b0};
    end
  end

endmodule

// File: rtl/irqCtrlControl.sv
module irqCtrlControl
  import irqCtrlPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         globalEn,
  input  logic         instrDone,
  input  logic         ackValid,
  input  logic         anyPending,
  output ctrlStrobes_t strobes,
  output logic         intReq
);

  ctrlState_t state;
  ctrlState_t stateNext;
  logic       fire;

  // Entry only at an instruction boundary, when enabled, and not awaiting ack
  assign fire = (state == ST_IDLE) && instrDone && globalEn && anyPending;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (fire)     stateNext = ST_WAIT_ACK;
      ST_WAIT_ACK: if (ackValid) stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign strobes.fire  = fire;
  assign strobes.clear = ackValid;
  assign intReq        = fire;

endmodule

// File: rtl/irqVecCtrl.sv
module irqVecCtrl
  import irqCtrlPkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SRC-1:0][ADDR_W-1:0] VEC_TABLE =
    '{16'hF040, 16'hF030, 16'hF020, 16'hF010},
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               globalEn,
  input  logic               instrDone,
  input  logic               ackValid,
  input  logic [IDX_W-1:0]   ackId,
  output logic               intReq,
  output logic [IDX_W-1:0]   intId,
  output logic [ADDR_W-1:0]  intVector
);

  ctrlStrobes_t strobes;
  logic         anyPending;

  irqCtrlControl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .globalEn   (globalEn),
    .instrDone  (instrDone),
    .ackValid   (ackValid),
    .anyPending (anyPending),
    .strobes    (strobes),
    .intReq     (intReq)
  );

  irqCtrlDatapath #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .VEC_TABLE (VEC_TABLE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .irqReq     (irqReq),
    .ackId      (ackId),
    .strobes    (strobes),
    .anyPending (anyPending),
    .intId      (intId),
    .intVector  (intVector)
  );

endmodule

// File: rtl/irqVecCtrlChecker.sv
module irqVecCtrlChecker #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SRC-1:0][ADDR_W-1:0] VEC_TABLE = '0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              globalEn,
  input logic              instrDone,
  input logic              ackValid,
  input logic              intReq,
  input logic [IDX_W-1:0]  intId,
  input logic [ADDR_W-1:0] intVector
);

  // Independent record of an interrupt handed out but not yet acknowledged
  logic waitingAck;
  always_ff @(posedge clk) begin
    if (rst)           waitingAck <= 1'b0;
    else if (intReq)   waitingAck <= 1'b1;
    else if (ackValid) waitingAck <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!intReq && intId == '0 && intVector == '0)); // R1

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
    intReq |-> instrDone); // R3

  AST_ENABLE_MASK: assert property (@(posedge clk) disable iff (rst)
    !globalEn |-> !intReq); // R7

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    waitingAck |-> !intReq); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    intReq |=> !intReq); // R8

  AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (rst)
    intReq |-> (intVector == {VEC_TABLE[intId][ADDR_W-1:1], 1'b0})); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !intReq |-> (intId == '0 && intVector == '0)); // R9

endmodule

bind irqVecCtrl irqVecCtrlChecker #(
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W),
  .VEC_TABLE (VEC_TABLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .globalEn  (globalEn),
  .instrDone (instrDone),
  .ackValid  (ackValid),
  .intReq    (intReq),
  .intId     (intId),
  .intVector (intVector)
);

// File: tb/irqVecCtrl_bench.sv
`timescale 1ns/1ps
module irqVecCtrl_bench;
  localparam int NUM_SRC = 4;
  localparam int IDX_W   = 2;
  localparam int ADDR_W  = 16;

  logic               clk = 1'b0;
  logic               rst;
  logic [NUM_SRC-1:0] irqReq;
  logic               globalEn;
  logic               instrDone;
  logic               ackValid;
  logic [IDX_W-1:0]   ackId;
  logic               intReq;
  logic [IDX_W-1:0]   intId;
  logic [ADDR_W-1:0]  intVector;

  int          checks = 0;
  int          fails  = 0;
  bit          finished = 1'b0;
  int          expId[$];
  logic [15:0] expVec[$];

  always #2 clk = ~clk;

  irqVecCtrl u_irqVecCtrl (
    .clk(clk), .rst(rst), .irqReq(irqReq), .globalEn(globalEn),
    .instrDone(instrDone), .ackValid(ackValid), .ackId(ackId),
    .intReq(intReq), .intId(intId), .intVector(intVector)
  );

  function automatic logic [15:0] vecOf(int id);
    return 16'hF000 + 16'(16 * (id + 1));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every presented interrupt must match the next scoreboard entry
  always @(negedge clk) begin
    if (!rst && intReq) begin
      if (expId.size() == 0) begin
        check(1'b0, "R3", "unexpected intReq", 1, 0);
      end else begin
        int          id;
        logic [15:0] v;
        id = expId.pop_front();
        v  = expVec.pop_front();
        check(int'(intId) == id, "R4", "presented source", int'(intId), id);
        check(intVector == v, "R5", "vector address", int'(intVector), int'(v));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver: one boundary cycle, pushing the expectation when a fire is due
  task automatic boundary(bit fire, int id, string req);
    if (fire) begin
      expId.push_back(id);
      expVec.push_back(vecOf(id));
    end
    instrDone = 1'b1;
    @(negedge clk); #0.5;
    check(intReq == fire, req, "intReq at boundary", int'(intReq), int'(fire));
    if (fire) check(expId.size() == 0, req, "expected entry consumed", expId.size(), 0);
    expId.delete();
    expVec.delete();
    step();
    instrDone = 1'b0;
  endtask

  task automatic raise(logic [NUM_SRC-1:0] m);
    irqReq = irqReq | m;
    step();
    irqReq = irqReq & ~m;
  endtask

  task automatic ack(int id);
    ackValid = 1'b1;
    ackId    = IDX_W'(id);
    step();
    ackValid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; irqReq = '0; globalEn = 1'b1; instrDone = 1'b0;
    ackValid = 1'b0; ackId = '0;
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs right after reset; R9 zero when idle
    check(intReq == 1'b0, "R1", "intReq after reset", int'(intReq), 0);
    check(intId == '0 && intVector == '0, "R9", "idle id/vector", int'(intVector), 0);
    step();

    // R3: boundary with nothing pending
    boundary(1'b0, 0, "R3");

    // R2/R5: single source, then R8 no refire before ack, R6 cleared by ack
    raise(4'b0100);
    boundary(1'b1, 2, "R2");
    boundary(1'b0, 0, "R8");
    ack(2);
    boundary(1'b0, 0, "R6");

    // R2: level held high does not re-pend after clear
    irqReq[1] = 1'b1;
    step();
    boundary(1'b1, 1, "R2");
    ack(1);
    boundary(1'b0, 0, "R2");
    irqReq[1] = 1'b0;
    step();

    // R4/R8: simultaneous sources 1 and 3, served in order
    raise(4'b1010);
    boundary(1'b1, 1, "R4");
    ack(1);
    boundary(1'b1, 3, "R8");
    ack(3);

    // R3: pending but no instruction boundary
    raise(4'b0001);
    instrDone = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(intReq == 1'b0, "R3", "no boundary no intReq", int'(intReq), 0);
    end
    step();
    boundary(1'b1, 0, "R3");
    ack(0);

    // R7: enable low masks, pending kept
    globalEn = 1'b0;
    raise(4'b1100);
    boundary(1'b0, 0, "R7");
    boundary(1'b0, 0, "R7");
    globalEn = 1'b1;
    boundary(1'b1, 2, "R7");
    ack(2);
    boundary(1'b1, 3, "R7");
    ack(3);

    // R6: new edge in the same cycle as ack keeps the bit
    raise(4'b0010);
    boundary(1'b1, 1, "R6");
    ackValid = 1'b1; ackId = 2'd1; irqReq[1] = 1'b1;
    step();
    ackValid = 1'b0; irqReq[1] = 1'b0;
    boundary(1'b1, 1, "R6");
    ack(1);

    // R6: stray ack while idle clears pending
    globalEn = 1'b0;
    raise(4'b0100);
    ack(2);
    globalEn = 1'b1;
    boundary(1'b0, 0, "R6");

    // R4/R8: higher-priority source arrives while a lower one is being served
    raise(4'b1000);
    boundary(1'b1, 3, "R4");
    raise(4'b0001);
    boundary(1'b0, 0, "R8");
    ack(3);
    boundary(1'b1, 0, "R4");
    ack(0);
    boundary(1'b0, 0, "R8");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule